// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block runs commands on a three-wire serial EEPROM that holds 64 sixteen-bit words. A host hands it one command at a time: a 3-bit command code, a 6-bit word address and 16 bits of write data, with a one-cycle start request. The engine frames the command itself. It raises chip select, sends a start bit, the opcode and the address, and then either shifts 16 data bits out, clocks 16 data bits in, or stops after the header.

For the commands that program the array, the engine drops chip select for a half-period after the data. It then selects the device again and waits on the device's data line until that line reports ready. A timeout counter ends a poll that never completes and flags an error. The serial clock half-period is a parameter counted in system clock cycles. The host sees `cmd_busy` while a command is in flight and a one-cycle `cmd_done` at the end. At that point `rd_data` holds the word from the last read and `cmd_error` shows whether the poll timed out.

Top module: `uwire_eeprom_engine`

## Requirements
- R1: After reset `ee_cs`, `ee_sk`, `ee_di`, `cmd_busy`, `cmd_done` and `cmd_error` are 0 and `rd_data` is 0. While the engine is idle, all three serial outputs stay low.
- R2: Every frame starts with a header of 9 serial clocks, sent MSB first: a start bit of 1, two opcode bits and six address bits. The opcodes are read = 10, write = 01 and erase = 11, and each is followed by `cmd_addr`.
- R3: Erase-all, write-all, write-enable and write-disable send opcode 00. The next two bits select the command: write-disable 00, write-all 01, erase-all 10, write-enable 11. Four zero bits follow. Erase, erase-all, write-enable and write-disable frames are exactly 9 clocks long.
- R4: Write and write-all send the 16 bits of `cmd_wdata`, MSB first, right after the header. Their frame is 25 clocks long.
- R5: Read sends the header and then clocks 16 more bits, for a 25-clock frame. The engine samples `ee_do` at the end of each high half of those 16 clocks, MSB first. At `cmd_done`, `rd_data` holds the word that was read.
- R6: Each low half and each high half of `ee_sk` lasts `DIV_HALF` clock cycles. `ee_sk` is high only while `ee_cs` is high. `ee_di` changes only while `ee_sk` is low.
- R7: After the last bit of a write, erase, erase-all or write-all, the engine does the following in order:
  - it lowers `ee_cs` for `DIV_HALF` cycles;
  - it raises `ee_cs` again;
  - it waits while `ee_do` is 0;
  - it ends once `ee_do` is 1.

  The other commands use a single chip-select frame and do not poll.
- R8: If `ee_do` stays 0 for `BUSY_LIMIT` cycles of polling, the engine ends the command with `cmd_error` = 1. `cmd_error` is cleared when the next command is accepted.
- R9: `cmd_start` is accepted only while `cmd_busy` is 0, and `cmd_busy` is 1 from the next cycle until the command ends. `cmd_done` is a one-cycle pulse in the first idle cycle, and `cmd_busy` falls only together with it. A start request made while busy is ignored.
- R10: Between any two chip-select frames, including the reselect for polling, `ee_cs` stays low for at least `DIV_HALF` cycles.
- R11: `rd_data` changes only while a read command runs. Other commands leave it holding the last read word.
- R12: `cmd_code` encodes the commands as follows: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 write-enable, 6 write-disable. Code 7 acts as write-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle command request |
| cmd_code | input | 3 | Command code (R12) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data for write and write-all |
| cmd_busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| cmd_error | output | 1 | The ready poll timed out |
| rd_data | output | DATA_W | Last word read |
| ee_cs | output | 1 | Chip select to the EEPROM, active high |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The end of one command and the acceptance of the next can fall in the same cycle. The `cmd_done` cycle is already idle, so a start presented there must be taken. The bench does this by raising `cmd_start` for a second read on the very falling clock edge where it sees `cmd_done` for the first read. It then judges both reads: each must return its own word with its own header, and the number of chip-select frames must match. The checker confirms that the low gap before the new frame still lasts a full half-period.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    // Host-side command codes
    localparam logic [2:0] CMD_READ      = 3'd0;
    localparam logic [2:0] CMD_WRITE     = 3'd1;
    localparam logic [2:0] CMD_ERASE     = 3'd2;
    localparam logic [2:0] CMD_ERASE_ALL = 3'd3;
    localparam logic [2:0] CMD_WRITE_ALL = 3'd4;
    localparam logic [2:0] CMD_WR_EN     = 3'd5;
    localparam logic [2:0] CMD_WR_DIS    = 3'd6;

    // Opcode field on the wire
    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    // Selector bits sent after the special opcode
    localparam logic [1:0] SEL_WR_DIS    = 2'b00;
    localparam logic [1:0] SEL_WRITE_ALL = 2'b01;
    localparam logic [1:0] SEL_ERASE_ALL = 2'b10;
    localparam logic [1:0] SEL_WR_EN     = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_BIT_LO = 3'd2,
        ST_BIT_HI = 3'd3,
        ST_DESEL  = 3'd4,
        ST_RESEL  = 3'd5,
        ST_POLL   = 3'd6,
        ST_GAP    = 3'd7
    } seq_state_e;

endpackage

// File: rtl/uwire_half_div.sv
module uwire_half_div #(
    parameter int DIV_HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV_HALF <= 1) begin : g_every
            // Every cycle is a half-period; no counter needed.
            logic unused_div;
            assign unused_div = restart ^ clk ^ rst_n;
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(DIV_HALF);
            localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = run && (cnt_q == LAST);
                cnt_d = cnt_q + 1'b1;
                if (!run || restart || tick) begin
                    cnt_d = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/uwire_frame_build.sv
module uwire_frame_build
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int HDR_W   = 3 + ADDR_W,
    localparam int FRAME_W = HDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [2:0]         code,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits,
    output logic               is_read,
    output logic               is_prog
);
    localparam int PAD_W = ADDR_W - 2;

    logic [1:0]        op;
    logic [ADDR_W-1:0] afield;
    logic              has_data;

    always_comb begin
        op       = OP_SPECIAL;
        afield   = {SEL_WR_DIS, {PAD_W{1'b0}}};
        has_data = 1'b0;
        is_read  = 1'b0;
        is_prog  = 1'b0;
        case (code)
            CMD_READ: begin
                op      = OP_READ;
                afield  = addr;
                is_read = 1'b1;
            end
            CMD_WRITE: begin
                op       = OP_WRITE;
                afield   = addr;
                has_data = 1'b1;
                is_prog  = 1'b1;
            end
            CMD_ERASE: begin
                op      = OP_ERASE;
                afield  = addr;
                is_prog = 1'b1;
            end
            CMD_ERASE_ALL: begin
                afield  = {SEL_ERASE_ALL, {PAD_W{1'b0}}};
                is_prog = 1'b1;
            end
            CMD_WRITE_ALL: begin
                afield   = {SEL_WRITE_ALL, {PAD_W{1'b0}}};
                has_data = 1'b1;
                is_prog  = 1'b1;
            end
            CMD_WR_EN: begin
                afield = {SEL_WR_EN, {PAD_W{1'b0}}};
            end
            default: begin
                afield = {SEL_WR_DIS, {PAD_W{1'b0}}};
            end
        endcase
        frame = {1'b1, op, afield, (has_data ? wdata : {DATA_W{1'b0}})};
        nbits = (has_data || is_read) ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
    end
endmodule

// File: rtl/uwire_seq.sv
module uwire_seq
    import uwire_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int BUSY_LIMIT = 100000,
    localparam int HDR_W   = 3 + ADDR_W,
    localparam int FRAME_W = HDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1),
    localparam int PC_W    = $clog2(BUSY_LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               is_read,
    input  logic               is_prog,
    input  logic               tick,
    input  logic               ee_do,
    output logic               run,
    output logic               restart,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ee_cs,
    output logic               ee_sk,
    output logic               ee_di
);
    typedef struct packed {
        seq_state_e         state;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   left;
        logic [DATA_W-1:0]  rx;
        logic               rd_mode;
        logic               prog;
        logic [PC_W-1:0]    poll;
        logic               err;
        logic               done;
        logic               cs;
        logic               sk;
        logic               di;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.tx      = frame;
                    d.left    = nbits;
                    d.rd_mode = is_read;
                    d.prog    = is_prog;
                    d.err     = 1'b0;
                    d.state   = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) d.state = ST_BIT_LO;
            end
            ST_BIT_LO: begin
                if (tick) d.state = ST_BIT_HI;
            end
            ST_BIT_HI: begin
                if (tick) begin
                    if (q.rd_mode && (q.left <= CNT_W'(DATA_W))) begin
                        d.rx = {q.rx[DATA_W-2:0], ee_do};
                    end
                    d.tx   = {q.tx[FRAME_W-2:0], 1'b0};
                    d.left = q.left - 1'b1;
                    if (q.left == CNT_W'(1)) begin
                        d.state = q.prog ? ST_DESEL : ST_GAP;
                    end else begin
                        d.state = ST_BIT_LO;
                    end
                end
            end
            ST_DESEL: begin
                if (tick) d.state = ST_RESEL;
            end
            ST_RESEL: begin
                if (tick) begin
                    d.state = ST_POLL;
                    d.poll  = '0;
                end
            end
            ST_POLL: begin
                if (ee_do) begin
                    d.state = ST_GAP;
                end else if (q.poll == PC_W'(BUSY_LIMIT - 1)) begin
                    d.err   = 1'b1;
                    d.state = ST_GAP;
                end else begin
                    d.poll = q.poll + 1'b1;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        d.cs = (d.state == ST_LEAD) || (d.state == ST_BIT_LO) ||
               (d.state == ST_BIT_HI) || (d.state == ST_RESEL) ||
               (d.state == ST_POLL);
        d.sk = (d.state == ST_BIT_HI);
        d.di = ((d.state == ST_BIT_LO) || (d.state == ST_BIT_HI)) &&
               d.tx[FRAME_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run     = (q.state != ST_IDLE) && (q.state != ST_POLL);
    assign restart = (d.state != q.state);
    assign busy    = (q.state != ST_IDLE);
    assign done    = q.done;
    assign err     = q.err;
    assign rd_data = q.rx;
    assign ee_cs   = q.cs;
    assign ee_sk   = q.sk;
    assign ee_di   = q.di;
endmodule

// File: rtl/uwire_eeprom_engine.sv
module uwire_eeprom_engine #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int DIV_HALF   = 8,
    parameter int BUSY_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic              cmd_error,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int HDR_W   = 3 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic               is_read;
    logic               is_prog;
    logic               tick;
    logic               run;
    logic               restart;

    uwire_frame_build #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .code    (cmd_code),
        .addr    (cmd_addr),
        .wdata   (cmd_wdata),
        .frame   (frame),
        .nbits   (nbits),
        .is_read (is_read),
        .is_prog (is_prog)
    );

    uwire_half_div #(
        .DIV_HALF (DIV_HALF)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    uwire_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BUSY_LIMIT (BUSY_LIMIT)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cmd_start),
        .frame   (frame),
        .nbits   (nbits),
        .is_read (is_read),
        .is_prog (is_prog),
        .tick    (tick),
        .ee_do   (ee_do),
        .run     (run),
        .restart (restart),
        .busy    (cmd_busy),
        .done    (cmd_done),
        .err     (cmd_error),
        .rd_data (rd_data),
        .ee_cs   (ee_cs),
        .ee_sk   (ee_sk),
        .ee_di   (ee_di)
    );
endmodule

// File: rtl/uwire_eeprom_engine_chk.sv
module uwire_eeprom_engine_chk #(
    parameter int DATA_W   = 16,
    parameter int DIV_HALF = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_busy,
    input logic              cmd_done,
    input logic              cmd_error,
    input logic [DATA_W-1:0] rd_data,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di
);
    logic        sk_prev, cs_prev;
    logic [31:0] hi_cnt, lo_cnt;

    // Length of the current or last high run of ee_sk, and of the low run of ee_cs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_prev <= 1'b0;
            cs_prev <= 1'b0;
            hi_cnt  <= 32'd0;
            lo_cnt  <= 32'(DIV_HALF);
        end else begin
            sk_prev <= ee_sk;
            cs_prev <= ee_cs;
            if (ee_sk) begin
                hi_cnt <= sk_prev ? hi_cnt + 32'd1 : 32'd1;
            end
            if (!ee_cs) begin
                if (cs_prev) begin
                    lo_cnt <= 32'd1;
                end else if (lo_cnt < 32'(DIV_HALF)) begin
                    lo_cnt <= lo_cnt + 32'd1;
                end
            end
        end
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy |-> (!ee_cs && !ee_sk && !ee_di));

    assert_sk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    assert_di_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_di) |-> !ee_sk);

    assert_half_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> (hi_cnt == 32'(DIV_HALF)));

    assert_error_in_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_error) |-> cmd_busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> cmd_done);

    assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (lo_cnt >= 32'(DIV_HALF)));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy |=> $stable(rd_data));
endmodule

bind uwire_eeprom_engine uwire_eeprom_engine_chk #(
    .DATA_W   (DATA_W),
    .DIV_HALF (DIV_HALF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_busy  (cmd_busy),
    .cmd_done  (cmd_done),
    .cmd_error (cmd_error),
    .rd_data   (rd_data),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
);

// File: tb/sim_uwire_eeprom_engine.sv
`timescale 1ns/1ps
module sim_uwire_eeprom_engine;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int DIVH    = 3;
    localparam int LIMIT   = 200;
    localparam int BUSY_OK = 60;
    localparam int BUSY_NG = 400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic [2:0]        cmd_code = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              cmd_busy, cmd_done, cmd_error;
    logic [DATA_W-1:0] rd_data;
    logic              ee_cs, ee_sk, ee_di, ee_do;

    always #4 clk = ~clk;

    uwire_eeprom_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_HALF(DIVH), .BUSY_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
        .cmd_done(cmd_done), .cmd_error(cmd_error), .rd_data(rd_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 1031 + 7);
    endfunction

    // ---------------- device model ----------------
    logic [15:0] mem [64];
    int          bitcnt, n_m, busy_cnt, cs_rises, last_bits;
    logic [8:0]  hsr, last_hdr;
    logic [15:0] wsr;
    logic        rd_mode_m, rdbit, sk_p, cs_p;
    bit          we_m, stuck;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
            bitcnt <= 0; busy_cnt <= 0; cs_rises <= 0; last_bits <= 0;
            hsr <= '0; last_hdr <= '0; wsr <= '0; rd_mode_m <= 1'b0;
            rdbit <= 1'b0; sk_p <= 1'b0; cs_p <= 1'b0; we_m <= 1'b0;
        end else begin
            sk_p <= ee_sk;
            cs_p <= ee_cs;
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (ee_cs && !cs_p) begin
                cs_rises <= cs_rises + 1;
                bitcnt <= 0; hsr <= '0; wsr <= '0; rd_mode_m <= 1'b0;
            end else if (ee_cs && ee_sk && !sk_p) begin
                n_m = bitcnt + 1;
                bitcnt <= n_m;
                if (n_m <= 9) begin
                    hsr <= {hsr[7:0], ee_di};
                end else if (n_m <= 25) begin
                    wsr <= {wsr[14:0], ee_di};
                    if (hsr[7:6] == 2'b10) begin
                        rd_mode_m <= 1'b1;
                        rdbit <= mem[hsr[5:0]][25 - n_m];
                    end
                end
            end else if (!ee_cs && cs_p && bitcnt > 0) begin
                last_hdr <= hsr; last_bits <= bitcnt; rd_mode_m <= 1'b0;
                case (hsr[7:6])
                    2'b00: case (hsr[5:4])
                        2'b00: we_m <= 1'b0;
                        2'b11: we_m <= 1'b1;
                        2'b10: if (we_m) begin
                            for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
                            busy_cnt <= stuck ? BUSY_NG : BUSY_OK;
                        end
                        default: if (we_m && bitcnt == 25) begin
                            for (int i = 0; i < 64; i++) mem[i] <= wsr;
                            busy_cnt <= stuck ? BUSY_NG : BUSY_OK;
                        end
                    endcase
                    2'b01: if (we_m && bitcnt == 25) begin
                        mem[hsr[5:0]] <= wsr;
                        busy_cnt <= stuck ? BUSY_NG : BUSY_OK;
                    end
                    2'b11: if (we_m) begin
                        mem[hsr[5:0]] <= 16'hFFFF;
                        busy_cnt <= stuck ? BUSY_NG : BUSY_OK;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ee_do = ee_cs & (rd_mode_m ? rdbit : (busy_cnt == 0));

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [8:0]  hdr;
        logic [4:0]  nbits;
        logic [15:0] rd;
        logic        err;
        logic [1:0]  frames;
        logic        prog;
    } item_t;

    item_t       sbq[$];
    logic [15:0] ref_mem [64];
    bit          ref_we = 1'b0;
    logic [15:0] prev_rd = 16'h0;
    int          pushed = 0;
    int          dones = 0;
    int          prev_rises = 0;

    task automatic issue(input bit now, input logic [2:0] code,
                         input logic [5:0] a, input logic [15:0] w);
        item_t it;
        bit    prog, wrote;
        logic [1:0] op;
        logic [5:0] af;
        prog  = (code == 3'd1) || (code == 3'd2) || (code == 3'd3) || (code == 3'd4);
        wrote = prog && ref_we;
        op = 2'b00; af = 6'b000000;
        case (code)
            3'd0: begin op = 2'b10; af = a; end
            3'd1: begin op = 2'b01; af = a; if (ref_we) ref_mem[a] = w; end
            3'd2: begin op = 2'b11; af = a; if (ref_we) ref_mem[a] = 16'hFFFF; end
            3'd3: begin af = 6'b100000;
                        if (ref_we) for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF; end
            3'd4: begin af = 6'b010000;
                        if (ref_we) for (int i = 0; i < 64; i++) ref_mem[i] = w; end
            3'd5: begin af = 6'b110000; ref_we = 1'b1; end
            default: begin af = 6'b000000; ref_we = 1'b0; end
        endcase
        it.hdr    = {1'b1, op, af};
        it.nbits  = (code == 3'd0 || code == 3'd1 || code == 3'd4) ? 5'd25 : 5'd9;
        if (code == 3'd0) prev_rd = ref_mem[a];
        it.rd     = prev_rd;
        it.err    = stuck && wrote;
        it.frames = prog ? 2'd2 : 2'd1;
        it.prog   = prog;
        sbq.push_back(it);
        pushed++;
        if (!now) @(negedge clk);
        cmd_start = 1'b1; cmd_code = code; cmd_addr = a; cmd_wdata = w;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(cmd_busy === 1'b1, "R9", "busy after accept", {31'd0, cmd_busy}, 32'd1);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (cmd_done !== 1'b1);
    endtask

    always @(negedge clk) begin
        if (rst_n && cmd_done === 1'b1) begin
            item_t it;
            dones++;
            if (sbq.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
            end else begin
                it = sbq.pop_front();
                chk(last_hdr == it.hdr, "R2/R3/R12", "header bits",
                    {23'd0, last_hdr}, {23'd0, it.hdr});
                chk(last_bits == int'(it.nbits), "R4/R5", "frame clocks",
                    32'(last_bits), {27'd0, it.nbits});
                chk(rd_data == it.rd, "R5/R11", "rd_data", {16'd0, rd_data}, {16'd0, it.rd});
                chk(cmd_error == it.err, "R8", "error flag", {31'd0, cmd_error}, {31'd0, it.err});
                chk((cs_rises - prev_rises) == int'(it.frames), "R7", "cs frames",
                    32'(cs_rises - prev_rises), {30'd0, it.frames});
                if (it.prog && !it.err)
                    chk(busy_cnt == 0, "R7", "ended before ready", 32'(busy_cnt), 32'd0);
            end
            prev_rises = cs_rises;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        stuck = 1'b0;
        for (int i = 0; i < 64; i++) ref_mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1", "serial pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
        chk({cmd_busy, cmd_done, cmd_error} == 3'b000, "R1", "handshake", {29'd0, cmd_busy, cmd_done, cmd_error}, 32'd0);
        chk(rd_data == 16'h0, "R1", "rd_data", {16'd0, rd_data}, 32'd0);

        issue(0, 3'd5, 6'd0, 16'h0);      wait_done();   // R3 write-enable
        issue(0, 3'd1, 6'd5, 16'h1234);   wait_done();   // R4 write
        issue(0, 3'd0, 6'd5, 16'h0);      wait_done();   // R5 read
        issue(0, 3'd0, 6'd63, 16'h0);     wait_done();   // R5 top address
        issue(0, 3'd1, 6'd0, 16'h8001);   wait_done();   // R4 MSB and LSB
        issue(0, 3'd0, 6'd0, 16'h0);      wait_done();
        issue(0, 3'd2, 6'd5, 16'hBEEF);   wait_done();   // R2 erase, data ignored
        issue(0, 3'd0, 6'd5, 16'h0);      wait_done();
        issue(0, 3'd6, 6'd9, 16'h0);      wait_done();   // R3 write-disable
        issue(0, 3'd1, 6'd6, 16'h5555);   wait_done();   // R11 rd_data held
        issue(0, 3'd0, 6'd6, 16'h0);      wait_done();
        issue(0, 3'd7, 6'd3, 16'h0);      wait_done();   // R12 code 7
        issue(0, 3'd5, 6'd0, 16'h0);      wait_done();
        // R9 start in the done cycle is accepted
        issue(0, 3'd0, 6'd0, 16'h0);      wait_done();
        issue(1, 3'd0, 6'd63, 16'h0);     wait_done();
        issue(0, 3'd4, 6'd0, 16'h0F0F);   wait_done();   // R3 write-all
        issue(0, 3'd0, 6'd33, 16'h0);     wait_done();
        issue(0, 3'd3, 6'd0, 16'h0);      wait_done();   // R3 erase-all
        issue(0, 3'd0, 6'd1, 16'h0);      wait_done();
        // R9 a start while busy is ignored
        issue(0, 3'd1, 6'd7, 16'hA5A5);
        repeat (20) @(negedge clk);
        cmd_start = 1'b1; cmd_code = 3'd0; cmd_addr = 6'd63;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        chk(cmd_busy === 1'b0, "R9", "ignored start left no command", {31'd0, cmd_busy}, 32'd0);
        issue(0, 3'd0, 6'd7, 16'h0);      wait_done();
        // R8 poll timeout
        stuck = 1'b1;
        issue(0, 3'd1, 6'd9, 16'h1111);   wait_done();
        stuck = 1'b0;
        repeat (BUSY_NG + 50) @(negedge clk);
        issue(0, 3'd0, 6'd9, 16'h0);      wait_done();   // R8 error cleared
        repeat (10) @(negedge clk);
        chk(dones == pushed, "R9", "done count", 32'(dones), 32'(pushed));
        chk(sbq.size() == 0, "R9", "scoreboard drained", 32'(sbq.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule